// File: doc/BRIEF.md
# Fixed-Latency External Memory Sequencer

This block sits between up to four compiled datapath processes and a 64-bit external memory. Each process presents a command (load, store or memory copy) with an address, a copy destination and store data. The sequencer picks one pending command by fixed priority, then steps it through a cycle pattern whose length never varies. It drives the memory's 32-bit address register, a shared bidirectional 64-bit data bus, and separate one-bit read and write enables. Load data comes back on `rdata` with a one-cycle `done` pulse routed to the process that was granted.

A load is one address cycle with the read enable high, then six data cycles; the word on the bus in the sixth data cycle is the one kept. A store is a single cycle that carries the address, the data and the write enable together. A copy runs the load pattern from the source address, then writes the captured word to the destination address in one final cycle, eight cycles in all. Command codes on each 2-bit op field: `00` load, `01` store, `10` or `11` copy.

The control is one state machine with four states. IDLE is the only state that accepts a command: a pending store goes to WRITE, and a pending load or copy goes to RADDR. RADDR always moves on to RDATA. RDATA counts six data cycles, then goes to WRITE for a copy or back to IDLE for a load. WRITE always returns to IDLE.

Top module: `xmem_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_rd`, `mem_wr`, `grant` and `done` are all zero.
- R2: In IDLE, `grant` is a combinational one-hot vector selecting the lowest-index set bit of `req_valid`, and that requester's command is accepted at the next clock edge.
- R3: A load (op `00`) keeps `busy` high for exactly 7 cycles. `mem_rd` is high only in the first of them, with `mem_addr` equal to the request address.
- R4: For a load, the word on `mem_data` in the sixth data cycle is returned on `rdata`, and `done` pulses for one cycle on the granted requester's bit in the cycle after `busy` falls. Words present in earlier data cycles are discarded.
- R5: A store (op `01`) keeps `busy` high for exactly 1 cycle. In that cycle `mem_wr` is high, `mem_rd` is low, `mem_addr` is the request address and `mem_data` carries the request data. `done` then pulses as in R4.
- R6: A copy (op `10`) keeps `busy` high for exactly 8 cycles. It follows the R3/R4 read pattern on the source address, and in its last cycle it writes the captured word to the destination address with `mem_wr` high. `rdata` shows the copied word with the `done` pulse.
- R7: While `busy` is high, `grant` stays zero and no request is accepted. A request held through a command is accepted only once the block is back in IDLE.
- R8: `mem_rd` and `mem_wr` are never high together, and the block drives `mem_data` only in cycles with `mem_wr` high.
- R9: Op `11` behaves exactly as a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Command pending, one bit per requester |
| req_op | input | 2*NREQ | Command code per requester (00 load, 01 store, 1x copy) |
| req_addr | input | AW*NREQ | Load/store address, or copy source, per requester |
| req_dst | input | AW*NREQ | Copy destination address per requester |
| req_wdata | input | DW*NREQ | Store data per requester |
| grant | output | NREQ | One-hot acceptance in IDLE |
| busy | output | 1 | A command is in flight |
| done | output | NREQ | One-cycle completion pulse to the granted requester |
| rdata | output | DW | Last captured read word |
| mem_addr | output | AW | Memory address register |
| mem_data | inout | DW | Memory data register bus |
| mem_rd | output | 1 | Read enable |
| mem_wr | output | 1 | Write enable |

## Verification
The bench builds the block with its default parameters: four requesters, 32-bit addresses, 64-bit data and six read data cycles. A memory model puts an inverted word on the bus in data cycles one to five and the true word in cycle six. This makes a capture in any wrong cycle visible. Every requester runs every command code with all lower-priority requesters also pending, and all fifteen non-empty request masks are swept. This covers the whole priority order, the hold-off while busy, and each state path through the machine.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_COPY  = 2'b10,
        OP_COPYX = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RADDR,
        ST_RDATA,
        ST_WRITE
    } st_e;

endpackage

// File: rtl/xms_arb.sv
module xms_arb #(
    parameter int NREQ = 4
) (
    input  logic            en,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic            any
);
    // blocked[i] is set when some lower-index requester is pending
    logic [NREQ:0] blocked;

    assign blocked[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < NREQ; i++) begin : g_chain
            assign blocked[i+1] = blocked[i] | req[i];
            assign gnt[i]       = en & req[i] & ~blocked[i];
        end
    endgenerate

    assign any = en & blocked[NREQ];

endmodule

// File: rtl/xms_fsm.sv
module xms_fsm
    import xms_pkg::*;
#(
    parameter int DATA_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_op,
    input  logic cmd_copy,
    output logic busy,
    output logic rd_en,
    output logic wr_en,
    output logic capture,
    output logic finish
);
    localparam int            CW   = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_CYC - 1);

    st_e           st, st_nx;
    logic [CW-1:0] cnt;
    logic          last_beat;

    assign last_beat = (st == ST_RDATA) && (cnt == LAST);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = (start_op == OP_STORE) ? ST_WRITE : ST_RADDR;
            ST_RADDR: st_nx = ST_RDATA;
            ST_RDATA: if (last_beat) st_nx = cmd_copy ? ST_WRITE : ST_IDLE;
            ST_WRITE: st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and data-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st == ST_RDATA) ? cnt + 1'b1 : '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy    = (st != ST_IDLE);
        rd_en   = (st == ST_RADDR);
        wr_en   = (st == ST_WRITE);
        capture = last_beat;
        finish  = (last_beat && !cmd_copy) || (st == ST_WRITE);
    end

endmodule

// File: rtl/xms_dpath.sv
module xms_dpath
    import xms_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 32,
    parameter int DW   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [NREQ-1:0]    gnt,
    input  logic [2*NREQ-1:0]  req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [AW*NREQ-1:0] req_dst,
    input  logic [DW*NREQ-1:0] req_wdata,
    input  logic               capture,
    input  logic               wr_phase,
    input  logic               finish,
    input  logic [DW-1:0]      bus_in,
    output op_e                sel_op,
    output logic               cmd_copy,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      wr_val,
    output logic [DW-1:0]      rdata,
    output logic [NREQ-1:0]    done
);
    logic [1:0]      sel_op_raw;
    logic [AW-1:0]   sel_addr, sel_dst;
    logic [DW-1:0]   sel_wdata;

    logic [NREQ-1:0] own_q;
    logic [AW-1:0]   addr_q, dst_q;
    logic [DW-1:0]   wdata_q, rbuf_q;

    // one-hot select of the granted requester's fields
    always_comb begin
        sel_op_raw = '0;
        sel_addr   = '0;
        sel_dst    = '0;
        sel_wdata  = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) begin
                sel_op_raw = sel_op_raw | req_op[2*i +: 2];
                sel_addr   = sel_addr   | req_addr[AW*i +: AW];
                sel_dst    = sel_dst    | req_dst[AW*i +: AW];
                sel_wdata  = sel_wdata  | req_wdata[DW*i +: DW];
            end
        end
    end

    assign sel_op = op_e'(sel_op_raw);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q    <= '0;
            cmd_copy <= 1'b0;
            addr_q   <= '0;
            dst_q    <= '0;
            wdata_q  <= '0;
            rbuf_q   <= '0;
            done     <= '0;
        end else begin
            if (accept) begin
                own_q    <= gnt;
                cmd_copy <= sel_op_raw[1];
                addr_q   <= sel_addr;
                dst_q    <= sel_dst;
                wdata_q  <= sel_wdata;
            end
            if (capture) rbuf_q <= bus_in;
            done <= finish ? own_q : '0;
        end
    end

    assign mem_addr = (wr_phase && cmd_copy) ? dst_q : addr_q;
    assign wr_val   = cmd_copy ? rbuf_q : wdata_q;
    assign rdata    = rbuf_q;

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xms_pkg::*;
#(
    parameter int NREQ     = 4,
    parameter int AW       = 32,
    parameter int DW       = 64,
    parameter int DATA_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    req_valid,
    input  logic [2*NREQ-1:0]  req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [AW*NREQ-1:0] req_dst,
    input  logic [DW*NREQ-1:0] req_wdata,
    output logic [NREQ-1:0]    grant,
    output logic               busy,
    output logic [NREQ-1:0]    done,
    output logic [DW-1:0]      rdata,
    output logic [AW-1:0]      mem_addr,
    inout  wire  [DW-1:0]      mem_data,
    output logic               mem_rd,
    output logic               mem_wr
);
    logic          any_req, capture, finish, cmd_copy;
    op_e           sel_op;
    logic [DW-1:0] wr_val;

    xms_arb #(.NREQ(NREQ)) u_arb (
        .en  (!busy),
        .req (req_valid),
        .gnt (grant),
        .any (any_req)
    );

    xms_fsm #(.DATA_CYC(DATA_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (any_req),
        .start_op (sel_op),
        .cmd_copy (cmd_copy),
        .busy     (busy),
        .rd_en    (mem_rd),
        .wr_en    (mem_wr),
        .capture  (capture),
        .finish   (finish)
    );

    xms_dpath #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (any_req),
        .gnt       (grant),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_dst   (req_dst),
        .req_wdata (req_wdata),
        .capture   (capture),
        .wr_phase  (mem_wr),
        .finish    (finish),
        .bus_in    (mem_data),
        .sel_op    (sel_op),
        .cmd_copy  (cmd_copy),
        .mem_addr  (mem_addr),
        .wr_val    (wr_val),
        .rdata     (rdata),
        .done      (done)
    );

    assign mem_data = mem_wr ? wr_val : {DW{1'bz}};

endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk #(
    parameter int NREQ = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] grant,
    input logic            busy,
    input logic [NREQ-1:0] done,
    input logic            mem_rd,
    input logic            mem_wr
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_rd && !mem_wr && done == '0));

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (busy && !mem_rd && !mem_wr));

    p_done_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    p_done_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |-> ($past(busy) && !$past(mem_rd)));

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    p_no_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (grant == '0));

    p_grant_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> busy);

    p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind xmem_seq xmem_seq_chk #(.NREQ(NREQ)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant  (grant),
    .busy   (busy),
    .done   (done),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
);

// File: tb/sim_xmem_seq.sv
`timescale 1ns/1ps
module sim_xmem_seq;
    localparam int NREQ = 4;
    localparam int AW   = 32;
    localparam int DW   = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [2*NREQ-1:0]  req_op = '0;
    logic [AW*NREQ-1:0] req_addr = '0;
    logic [AW*NREQ-1:0] req_dst = '0;
    logic [DW*NREQ-1:0] req_wdata = '0;
    logic [NREQ-1:0]    grant, done;
    logic               busy, mem_rd, mem_wr;
    logic [DW-1:0]      rdata;
    logic [AW-1:0]      mem_addr;
    wire  [DW-1:0]      mem_bus;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    xmem_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_dst(req_dst), .req_wdata(req_wdata),
        .grant(grant), .busy(busy), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_data(mem_bus), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // memory model: inverted word in data cycles 1..5, true word in cycle 6
    logic [DW-1:0] mdl [16];
    logic [DW-1:0] expm [16];
    logic [2:0]    m_cnt = '0;
    logic [3:0]    m_a = '0;
    logic [DW-1:0] m_val;

    assign m_val   = (m_cnt == 3'd6) ? mdl[m_a] : ~mdl[m_a];
    assign mem_bus = (m_cnt != 3'd0) ? m_val : {DW{1'bz}};

    always @(posedge clk) begin
        if (mem_wr) mdl[mem_addr[3:0]] <= mem_bus;
        if (mem_rd) begin
            m_cnt <= 3'd1;
            m_a   <= mem_addr[3:0];
        end else if (m_cnt != 3'd0) begin
            m_cnt <= (m_cnt == 3'd6) ? 3'd0 : m_cnt + 3'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // one command from requester r with the request mask held
    task automatic run_cmd(input int r, input logic [1:0] op, input logic [3:0] mask,
                           input logic [3:0] ia, input logic [3:0] id, input logic [63:0] wd);
        logic [AW-1:0] a, d;
        logic [DW-1:0] src;
        int busy_n, rd_n, wr_n, rd_at, wr_at;
        logic [AW-1:0] rd_addr, wr_addr;
        logic [DW-1:0] wr_data;
        bit gbad, xbad;
        int exp_len;
        a = 32'hA500_0000 | AW'(ia);
        d = 32'h5A00_0000 | AW'(id);
        src = expm[ia];
        @(negedge clk);
        req_op[2*r +: 2]      = op;
        req_addr[AW*r +: AW]  = a;
        req_dst[AW*r +: AW]   = d;
        req_wdata[DW*r +: DW] = wd;
        req_valid = mask;
        #1;
        chk(grant == NREQ'(1 << r), "R2 grant", 64'(grant), 64'(1 << r));
        @(negedge clk);
        req_valid = mask & ~NREQ'(1 << r);
        busy_n = 0; rd_n = 0; wr_n = 0; rd_at = -1; wr_at = -1;
        rd_addr = '0; wr_addr = '0; wr_data = '0; gbad = 0; xbad = 0;
        while (busy && busy_n < 20) begin
            if (grant != '0) gbad = 1;
            if (mem_rd && mem_wr) xbad = 1;
            if (mem_rd) begin rd_n++; rd_at = busy_n; rd_addr = mem_addr; end
            if (mem_wr) begin wr_n++; wr_at = busy_n; wr_addr = mem_addr; wr_data = mem_bus; end
            busy_n++;
            @(negedge clk);
        end
        chk(!gbad, "R7 no grant while busy", 64'(gbad), 64'd0);
        chk(!xbad, "R8 rd/wr exclusive", 64'(xbad), 64'd0);
        chk(done == NREQ'(1 << r), "R4 done to granted requester", 64'(done), 64'(1 << r));
        exp_len = (op == 2'b00) ? 7 : (op == 2'b01) ? 1 : 8;
        if (op == 2'b00) begin
            chk(busy_n == 7, "R3 load length", 64'(busy_n), 64'd7);
            chk(rd_n == 1 && rd_at == 0 && rd_addr == a, "R3 load address cycle", 64'(rd_addr), 64'(a));
            chk(wr_n == 0, "R3 load no write", 64'(wr_n), 64'd0);
            chk(rdata == src, "R4 load data from sixth data cycle", rdata, src);
        end else if (op == 2'b01) begin
            chk(busy_n == 1, "R5 store length", 64'(busy_n), 64'd1);
            chk(rd_n == 0 && wr_n == 1 && wr_addr == a, "R5 store address", 64'(wr_addr), 64'(a));
            chk(wr_data == wd, "R5 store data", wr_data, wd);
            expm[ia] = wd;
            chk(mdl[ia] == wd, "R5 memory updated", mdl[ia], wd);
        end else begin
            chk(busy_n == exp_len, (op == 2'b11) ? "R9 copy length" : "R6 copy length", 64'(busy_n), 64'(exp_len));
            chk(rd_n == 1 && rd_at == 0 && rd_addr == a, "R6 copy source read", 64'(rd_addr), 64'(a));
            chk(wr_n == 1 && wr_at == 7 && wr_addr == d, (op == 2'b11) ? "R9 copy write" : "R6 copy destination write", 64'(wr_addr), 64'(d));
            chk(wr_data == src, "R6 copy data", wr_data, src);
            chk(rdata == src, "R6 copy rdata", rdata, src);
            expm[id] = src;
            chk(mdl[id] == src, "R6 destination updated", mdl[id], src);
        end
        req_valid = '0;
        @(negedge clk);
        chk(done == '0, "R4 done single cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mdl[i]  = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_1111_1111_1111);
            expm[i] = mdl[i];
        end
        repeat (3) @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr, "R1 reset idle", {61'd0, busy, mem_rd, mem_wr}, 64'd0);
        chk(done == '0 && grant == '0, "R1 reset outputs", 64'({done, grant}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && done == '0, "R1 after reset", 64'({busy, done}), 64'd0);

        // every requester, every op, lower-priority requesters pending
        for (int r = 0; r < NREQ; r++) begin
            for (int op = 0; op < 4; op++) begin
                run_cmd(r, 2'(op), 4'((4'hF << r) & 4'hF), 4'(r * 4 + op), 4'(15 - r * 4 - op),
                        64'hFEED_0000_0000_0000 | 64'(r * 16 + op));
            end
        end
        // priority sweep over every non-empty mask with stores
        for (int m = 1; m < 16; m++) begin
            int low;
            low = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) low = b;
            run_cmd(low, 2'b01, 4'(m), 4'(m), 4'd0, 64'hC0DE_0000_0000_0000 | 64'(m));
        end
        // read back a few stored words
        for (int k = 1; k < 16; k += 5) begin
            run_cmd(k % NREQ, 2'b00, 4'(1 << (k % NREQ)), 4'(k), 4'd0, 64'd0);
        end
        finish_run();
    end

endmodule